// File: doc/BRIEF.md
# Processor Status Flags and Conditional Branch Evaluator

This block keeps the eight condition flags of a small processor core in one status register and decides conditional relative branches against them. Each cycle a decoder presents one operation with its operands. The block then works out the next program counter, says whether a branch is taken and what that costs in cycles, and gives back a register operand that may have been rewritten for a bit-load. Flag writes take effect at the next clock edge.

The flags sit in a fixed order from the most significant bit down: global interrupt enable (bit 7), user bit T (bit 6), half carry H (bit 5), signed result S (bit 4), overflow V (bit 3), negative N (bit 2), zero Z (bit 1) and carry C (bit 0). A flag index picks one of them for branch tests and for set or clear operations. A branch on index 4 does not test the stored S bit. It tests N XOR V, which gives the signed less-than and greater-or-equal comparisons. The T bit can also be loaded from any bit of a register operand, or copied into one.

Top module: `status_branch_unit`

## Requirements
- R1: While reset is asserted and after it is released with no operation, the status output is 8'h00.
- R2: A taken branch gives pc_next = pc_in + sign-extended offset + 1, modulo 2^PC_W, taken = 1 and cycles = 2.
- R3: A branch that is not taken, a flag set or clear, a bit-store and a bit-load each give pc_next = pc_in + 1, taken = 0 and cycles = 1. When op_valid is 0 the outputs are pc_next = pc_in, taken = 0 and cycles = 0.
- R4: Opcode 3'd1 (branch if set) is taken when status[flag_sel] is 1. Opcode 3'd2 (branch if clear) is taken when it is 0. This holds for every index except 4.
- R5: With flag_sel = 4 the condition is N XOR V (status[2] ^ status[3]), not status[4]. Opcode 3'd1 is therefore signed less-than and opcode 3'd2 is signed greater-or-equal.
- R6: Opcode 3'd3 sets status[flag_sel] and opcode 3'd4 clears it at the next clock edge. All other flags keep their values.
- R7: Opcode 3'd5 (bit store) writes reg_in[bit_sel] into T (status[6]) at the next clock edge. All other flags keep their values.
- R8: Opcode 3'd6 (bit load) gives reg_out equal to reg_in with bit bit_sel replaced by T and leaves the status unchanged. For every other operation reg_out equals reg_in.
- R9: Branch operations (opcodes 3'd1 and 3'd2) leave every status flag unchanged.
- R10: The 7-bit offset is two's complement. 7'h3F is +63 and 7'h40 is -64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 3 | 1 br-set, 2 br-clear, 3 flag set, 4 flag clear, 5 bit store, 6 bit load |
| flag_sel | input | 3 | Status bit index |
| offset | input | OFF_W (7) | Signed branch displacement |
| reg_in | input | 8 | Register operand |
| bit_sel | input | 3 | Bit index into reg_in |
| pc_in | input | PC_W (16) | Current program counter |
| pc_next | output | PC_W (16) | Next program counter |
| taken | output | 1 | Branch taken |
| cycles | output | 2 | Cycle cost of the operation |
| reg_out | output | 8 | Register operand after a possible bit load |
| status | output | 8 | Status register |

## Verification
The branch evaluator is driven with both opcodes on every flag index, each against two status patterns that are bitwise complements. A wrong bit index or an inverted polarity therefore shows up on the taken output. The signed index is run through all four N/V combinations with the stored S bit set opposite to the expected answer, which separates the XOR test from a plain read of bit 4. Offsets at +63, -64 and zero, with PC values near wrap-around, expose a missing sign extension or a dropped +1. Bit store and bit load are tried on the outer and middle bit positions, with T at both values.

// File: rtl/status_branch_unit.sv
module status_branch_unit #(
  parameter int PC_W  = 16,
  parameter int OFF_W = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [2:0]      op_code,
  input  logic [2:0]      flag_sel,
  input  logic [OFF_W-1:0] offset,
  input  logic [7:0]      reg_in,
  input  logic [2:0]      bit_sel,
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] pc_next,
  output logic            taken,
  output logic [1:0]      cycles,
  output logic [7:0]      reg_out,
  output logic [7:0]      status
);
  localparam logic [2:0] OP_BSET = 3'd1, OP_BCLR = 3'd2, OP_FSET = 3'd3,
                         OP_FCLR = 3'd4, OP_TST  = 3'd5, OP_TLD  = 3'd6;
  localparam int T_IDX = 6, S_IDX = 4, V_IDX = 3, N_IDX = 2;

  logic [7:0] st_q;
  logic       is_br, cond;
  logic [PC_W-1:0] disp;

  assign is_br = op_valid && (op_code == OP_BSET || op_code == OP_BCLR);
  assign cond  = (flag_sel == 3'(S_IDX)) ? (st_q[N_IDX] ^ st_q[V_IDX]) : st_q[flag_sel];
  assign taken = is_br && ((op_code == OP_BSET) ? cond : !cond);
  assign disp  = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};

  always_comb begin
    if (!op_valid) begin
      pc_next = pc_in;
      cycles  = 2'd0;
    end else if (taken) begin
      pc_next = pc_in + disp + PC_W'(1);
      cycles  = 2'd2;
    end else begin
      pc_next = pc_in + PC_W'(1);
      cycles  = 2'd1;
    end
  end

  always_comb begin
    reg_out = reg_in;
    if (op_valid && op_code == OP_TLD) reg_out[bit_sel] = st_q[T_IDX];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else if (op_valid) begin
      case (op_code)
        OP_FSET: st_q[flag_sel] <= 1'b1;
        OP_FCLR: st_q[flag_sel] <= 1'b0;
        OP_TST:  st_q[T_IDX]    <= reg_in[bit_sel];
        default: ;
      endcase
    end
  end

  assign status = st_q;

  AST_BRANCH_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) is_br |=> $stable(status)); // R9
  AST_FLAG_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_FSET) |=> status[$past(flag_sel)]); // R6
  AST_FLAG_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_FCLR) |=> !status[$past(flag_sel)]); // R6
  AST_T_STORE: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_TST) |=> status[T_IDX] == $past(reg_in[bit_sel])); // R7
  AST_LOAD_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_TLD) |-> $countones(reg_out ^ reg_in) <= 1); // R8
  AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == OP_TLD) |=> $stable(status)); // R8
  AST_TAKEN_COST: assert property (@(posedge clk) disable iff (!rst_n) taken |-> cycles == 2'd2); // R2
  AST_TAKEN_NEEDS_BRANCH: assert property (@(posedge clk) disable iff (!rst_n) taken |-> (op_valid && (op_code == OP_BSET || op_code == OP_BCLR))); // R4
endmodule

// File: tb/status_branch_unit_tb.sv
module status_branch_unit_tb_top;
  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [2:0] op_code = 0, flag_sel = 0, bit_sel = 0;
  logic [6:0] offset = 0;
  logic [7:0] reg_in = 0, reg_out, status;
  logic [15:0] pc_in = 0, pc_next;
  logic taken;
  logic [1:0] cycles;
  int n_chk = 0, n_err = 0;
  logic [7:0] exp_st = 8'h00;

  always #2 clk = ~clk;

  status_branch_unit dut_i (.clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .flag_sel(flag_sel), .offset(offset), .reg_in(reg_in), .bit_sel(bit_sel), .pc_in(pc_in),
    .pc_next(pc_next), .taken(taken), .cycles(cycles), .reg_out(reg_out), .status(status));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [2:0] op, logic [2:0] fs, logic [6:0] off,
                       logic [7:0] ri, logic [2:0] bs, logic [15:0] pc);
    @(negedge clk);
    op_valid = v; op_code = op; flag_sel = fs; offset = off;
    reg_in = ri; bit_sel = bs; pc_in = pc;
    #1;
  endtask

  task automatic step_idle();
    @(negedge clk);
    op_valid = 0;
    #1;
  endtask

  function automatic logic want_take(logic [2:0] op, logic [2:0] fs, logic [7:0] st);
    logic c;
    c = (fs == 3'd4) ? (st[2] ^ st[3]) : st[fs];
    return (op == 3'd1) ? c : !c;
  endfunction

  task automatic load_status(logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      drive(1, v[i] ? 3'd3 : 3'd4, 3'(i), 0, 0, 0, 0);
      chk("R3 flag op pc", {16'h0, pc_next}, 32'h1);
    end
    step_idle();
    exp_st = v;
    chk("R6 status after load", {24'h0, status}, {24'h0, v});
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    #1 chk("R1 status in reset", {24'h0, status}, 0);
    rst_n = 1;
    drive(0, 3'd1, 0, 7'h05, 8'hAA, 0, 16'h1234);
    chk("R1 status after reset", {24'h0, status}, 0);
    chk("R3 idle pc", {16'h0, pc_next}, 32'h1234);
    chk("R3 idle cycles", {30'h0, cycles}, 0);
    chk("R3 idle taken", {31'h0, taken}, 0);
  endtask

  task automatic t_flags();
    for (int i = 0; i < 8; i++) begin
      drive(1, 3'd3, 3'(i), 0, 0, 0, 0);
      step_idle();
      exp_st[i] = 1'b1;
      chk("R6 set accumulates", {24'h0, status}, {24'h0, exp_st});
    end
    drive(1, 3'd4, 3'd5, 0, 0, 0, 0);
    step_idle();
    exp_st[5] = 1'b0;
    chk("R6 clear one bit", {24'h0, status}, {24'h0, exp_st});
  endtask

  task automatic t_branch_all(logic [7:0] pat);
    logic e;
    load_status(pat);
    for (int op = 1; op <= 2; op++)
      for (int fs = 0; fs < 8; fs++) begin
        drive(1, 3'(op), 3'(fs), 7'h05, 0, 0, 16'h0100);
        e = want_take(3'(op), 3'(fs), pat);
        chk(fs == 4 ? "R5 taken" : "R4 taken", {31'h0, taken}, {31'h0, e});
        chk(e ? "R2 pc" : "R3 pc", {16'h0, pc_next}, e ? 32'h0106 : 32'h0101);
        chk(e ? "R2 cycles" : "R3 cycles", {30'h0, cycles}, e ? 2 : 1);
      end
    step_idle();
    chk("R9 branches keep status", {24'h0, status}, {24'h0, pat});
  endtask

  task automatic t_signed();
    for (int nv = 0; nv < 4; nv++) begin
      logic n, v, lt;
      n = nv[1]; v = nv[0]; lt = n ^ v;
      load_status({3'b000, !lt, v, n, 2'b00});
      drive(1, 3'd1, 3'd4, 7'h02, 0, 0, 16'h0010);
      chk("R5 signed lt", {31'h0, taken}, {31'h0, lt});
      drive(1, 3'd2, 3'd4, 7'h02, 0, 0, 16'h0010);
      chk("R5 signed ge", {31'h0, taken}, {31'h0, !lt});
    end
  endtask

  task automatic t_offset();
    load_status(8'h01);
    drive(1, 3'd1, 3'd0, 7'h3F, 0, 0, 16'h1000);
    chk("R10 offset +63", {16'h0, pc_next}, 32'h1040);
    drive(1, 3'd1, 3'd0, 7'h40, 0, 0, 16'h1000);
    chk("R10 offset -64", {16'h0, pc_next}, 32'h0FC1);
    drive(1, 3'd1, 3'd0, 7'h7F, 0, 0, 16'h0000);
    chk("R2 offset -1 gives pc", {16'h0, pc_next}, 32'h0000);
    drive(1, 3'd1, 3'd0, 7'h01, 0, 0, 16'hFFFF);
    chk("R2 wrap", {16'h0, pc_next}, 32'h0001);
    drive(1, 3'd2, 3'd0, 7'h10, 0, 0, 16'hFFFF);
    chk("R3 not taken wrap", {16'h0, pc_next}, 32'h0000);
  endtask

  task automatic t_bits();
    load_status(8'h00);
    drive(1, 3'd5, 0, 0, 8'h80, 3'd7, 0);
    chk("R3 store pc", {16'h0, pc_next}, 1);
    step_idle();
    chk("R7 store 1 from bit 7", {24'h0, status}, 32'h40);
    drive(1, 3'd6, 0, 0, 8'h00, 3'd3, 0);
    chk("R8 load T=1", {24'h0, reg_out}, 32'h08);
    chk("R3 load cycles", {30'h0, cycles}, 1);
    step_idle();
    chk("R8 load keeps status", {24'h0, status}, 32'h40);
    drive(1, 3'd5, 0, 0, 8'hFE, 3'd0, 0);
    step_idle();
    chk("R7 store 0 from bit 0", {24'h0, status}, 32'h00);
    drive(1, 3'd6, 0, 0, 8'hFF, 3'd0, 0);
    chk("R8 load T=0", {24'h0, reg_out}, 32'hFE);
    drive(1, 3'd1, 0, 0, 8'h5A, 3'd2, 0);
    chk("R8 passthrough", {24'h0, reg_out}, 32'h5A);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_flags();
        t_branch_all(8'hA5);
        t_branch_all(8'h5A);
        t_signed();
        t_offset();
        t_bits();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule